// File: doc/BRIEF.md
# Low-Power Watchdog Timer Controller

This block is a watchdog counter that runs in a slow watchdog clock domain. Three candidate low-frequency sources arrive as tick strobes, sampled in that domain. A select field picks one of them, and the counter advances on each tick of the chosen source. The timeout depends on a 4-bit period field: it is 2^(3+period)+1 ticks, so it spans 9 to 262145 ticks. If software does not clear the counter before the timeout, the block raises a one-cycle reset request and then holds the count.

Counting can be suspended without losing the count. A debugger halt suspends it unless the debug-run bit is set. Sleep modes 2 and 3 suspend it unless their own run bits are set. Power mode 4 always suspends it. When counting is allowed again, it resumes from the held value.

Software clears the counter with a pulse in the bus clock domain. A toggle crosses into the watchdog domain through two flops. The block also drives two lock outputs. One keeps the selected oscillator alive and started. The other stops the CPU from entering the deepest sleep mode. Deasserting the enable returns the whole block to its reset state.

All pins are plain control and status levels. There is no streamed data, so there is no valid/ready handshake and no back-pressure.

Top module: `lpwdt_ctrl`

## Requirements
- R1: The counter advances by one on each `clk` edge where the tick of the selected source is high. `clk_sel` values 0, 1 and 2 select `src_tick[0]`, `src_tick[1]` and `src_tick[2]`. The value 3 selects no source, so the counter never advances.
- R2: Starting from zero, the counter expires after 2^(3+`per_sel`)+1 ticks. `rst_req` is high for exactly the one cycle that follows the edge on which the count reaches that value.
- R3: After expiry the count holds at its final value, and no further `rst_req` pulse occurs until a clear or a disable.
- R4: While `dbg_halt` is 1 and `dbg_run` is 0, the count does not change. While `dbg_run` is 1, a halt has no effect on counting.
- R5: `pwr_mode` codes 0 and 1 always count. Code 2 counts only when `em2_run` is 1, and code 3 counts only when `em3_run` is 1. Code 4, and the unused codes 5 to 7, never count.
- R6: When counting is allowed again after a freeze, the count continues from the held value, so a run frozen for F cycles times out F cycles later.
- R7: A one-cycle `clr` pulse in the `bus_clk` domain returns the count to zero within four `clk` cycles of reaching the watchdog domain. A clear wins over a tick on the same edge.
- R8: After a clear followed by a change of `per_sel`, the next timeout comes after the new period, measured from zero.
- R9: While `en` is 0, `count` is 0, `rst_req` is 0 and both lock outputs are 0. A clear issued while disabled is discarded and does not act after enable.
- R10: `osc_req` is the one-hot code of `clk_sel` (bit i for source i) while `en` and `osc_lock` are both 1. Otherwise it is 0.
- R11: `deep_sleep_block` is 1 exactly while `en` and `em4_block` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog domain clock |
| rst_n | input | 1 | Asynchronous active-low reset, watchdog domain |
| bus_clk | input | 1 | Bus clock for the clear command |
| bus_rst_n | input | 1 | Asynchronous active-low reset, bus domain |
| clr | input | 1 | Clear command pulse, bus domain |
| en | input | 1 | Watchdog enable; 0 returns the block to reset state |
| src_tick | input | 3 | Tick strobes of the three candidate sources |
| clk_sel | input | 2 | Source select (0..2, 3 = none) |
| per_sel | input | 4 | Period select |
| dbg_halt | input | 1 | Debugger halt indication |
| dbg_run | input | 1 | Keep counting during a debugger halt |
| pwr_mode | input | 3 | Current power mode code (0..4) |
| em2_run | input | 1 | Keep counting in mode 2 |
| em3_run | input | 1 | Keep counting in mode 3 |
| osc_lock | input | 1 | Keep the selected oscillator locked on |
| em4_block | input | 1 | Forbid entry into mode 4 |
| rst_req | output | 1 | One-cycle reset request on timeout |
| osc_req | output | 3 | Per-source keep-alive / start request |
| deep_sleep_block | output | 1 | Blocks entry into mode 4 |
| count | output | 19 | Current counter value |

## Verification
The hardest situation to reach is a clear that lands while the counter is running. The clear crosses clock domains, so its arrival cycle depends on the phase between the two clocks, and the next timeout cycle cannot be predicted from the ports. The stimulus avoids this by freezing the counter with a debugger halt before issuing the clear, and by changing the period while still frozen. Once the halt is released, the count is known to start from zero and the timeout cycle can be predicted exactly. Long freezes in several power-mode codes are strung into one run, so a single predicted pulse time covers every resume.

// File: rtl/lpwdt_pkg.sv
package lpwdt_pkg;
  typedef enum logic [2:0] {
    PM_ACTIVE = 3'd0,
    PM_LIGHT  = 3'd1,
    PM_SLEEP2 = 3'd2,
    PM_SLEEP3 = 3'd3,
    PM_OFF    = 3'd4
  } pmode_e;
endpackage

// File: rtl/lpwdt_clr_sync.sv
module lpwdt_clr_sync #(
  parameter int STAGES = 2
) (
  input  logic bus_clk,
  input  logic bus_rst_n,
  input  logic clr,
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic clr_hit
);
  logic              req_tgl;
  logic [STAGES-1:0] sync_q;
  logic              seen_q;

  // bus side: each command flips the request level
  always_ff @(posedge bus_clk or negedge bus_rst_n) begin
    if (!bus_rst_n) req_tgl <= 1'b0;
    else if (clr)   req_tgl <= ~req_tgl;
  end

  // watchdog side: synchronise, then detect a level change
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      seen_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], req_tgl};
      seen_q <= sync_q[STAGES-1];
    end
  end

  // while disabled, arriving toggles are absorbed and dropped
  assign clr_hit = en && (sync_q[STAGES-1] ^ seen_q);
endmodule

// File: rtl/lpwdt_run_gate.sv
module lpwdt_run_gate
  import lpwdt_pkg::*;
#(
  parameter int NSRC  = 3,
  parameter int SEL_W = 2
) (
  input  logic [NSRC-1:0]  src_tick,
  input  logic [SEL_W-1:0] clk_sel,
  input  logic             en,
  input  logic             dbg_halt,
  input  logic             dbg_run,
  input  logic [2:0]       pwr_mode,
  input  logic             em2_run,
  input  logic             em3_run,
  output logic             step
);
  logic sel_tick;
  logic mode_ok;

  always_comb begin
    sel_tick = 1'b0;
    for (int i = 0; i < NSRC; i++)
      if (clk_sel == SEL_W'(i)) sel_tick = src_tick[i];
  end

  always_comb begin
    unique case (pwr_mode)
      PM_ACTIVE, PM_LIGHT: mode_ok = 1'b1;
      PM_SLEEP2:           mode_ok = em2_run;
      PM_SLEEP3:           mode_ok = em3_run;
      default:             mode_ok = 1'b0;
    endcase
  end

  assign step = en && sel_tick && mode_ok && (!dbg_halt || dbg_run);
endmodule

// File: rtl/lpwdt_counter.sv
module lpwdt_counter #(
  parameter int PER_W    = 4,
  parameter int BASE_EXP = 3,
  parameter int CNT_W    = BASE_EXP + (1 << PER_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             step,
  input  logic             clr,
  input  logic [PER_W-1:0] per_sel,
  output logic [CNT_W-1:0] count,
  output logic             rst_req
);
  logic [CNT_W-1:0] limit;
  logic [CNT_W:0]   nxt;
  logic             expired;

  assign limit = (CNT_W'(1) << (BASE_EXP + 32'(per_sel))) + CNT_W'(1);
  assign nxt   = {1'b0, count} + (CNT_W+1)'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count   <= '0;
      expired <= 1'b0;
      rst_req <= 1'b0;
    end else if (!en) begin
      count   <= '0;
      expired <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      rst_req <= 1'b0;
      if (clr) begin
        count   <= '0;
        expired <= 1'b0;
      end else if (step && !expired) begin
        count <= nxt[CNT_W-1:0];
        // >= so a shortened period still expires
        if (nxt >= {1'b0, limit}) begin
          expired <= 1'b1;
          rst_req <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/lpwdt_lock.sv
module lpwdt_lock #(
  parameter int NSRC  = 3,
  parameter int SEL_W = 2
) (
  input  logic             en,
  input  logic             osc_lock,
  input  logic             em4_block,
  input  logic [SEL_W-1:0] clk_sel,
  output logic [NSRC-1:0]  osc_req,
  output logic             deep_sleep_block
);
  for (genvar i = 0; i < NSRC; i++) begin : g_req
    assign osc_req[i] = en && osc_lock && (clk_sel == SEL_W'(i));
  end
  assign deep_sleep_block = en && em4_block;
endmodule

// File: rtl/lpwdt_ctrl.sv
module lpwdt_ctrl #(
  parameter int NSRC        = 3,
  parameter int SEL_W       = 2,
  parameter int PER_W       = 4,
  parameter int BASE_EXP    = 3,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = BASE_EXP + (1 << PER_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_clk,
  input  logic             bus_rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic [NSRC-1:0]  src_tick,
  input  logic [SEL_W-1:0] clk_sel,
  input  logic [PER_W-1:0] per_sel,
  input  logic             dbg_halt,
  input  logic             dbg_run,
  input  logic [2:0]       pwr_mode,
  input  logic             em2_run,
  input  logic             em3_run,
  input  logic             osc_lock,
  input  logic             em4_block,
  output logic             rst_req,
  output logic [NSRC-1:0]  osc_req,
  output logic             deep_sleep_block,
  output logic [CNT_W-1:0] count
);
  logic clr_hit;
  logic step;

  lpwdt_clr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .clr(clr),
    .clk(clk), .rst_n(rst_n), .en(en), .clr_hit(clr_hit)
  );

  lpwdt_run_gate #(.NSRC(NSRC), .SEL_W(SEL_W)) u_gate (
    .src_tick(src_tick), .clk_sel(clk_sel), .en(en),
    .dbg_halt(dbg_halt), .dbg_run(dbg_run), .pwr_mode(pwr_mode),
    .em2_run(em2_run), .em3_run(em3_run), .step(step)
  );

  lpwdt_counter #(.PER_W(PER_W), .BASE_EXP(BASE_EXP), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(en), .step(step), .clr(clr_hit),
    .per_sel(per_sel), .count(count), .rst_req(rst_req)
  );

  lpwdt_lock #(.NSRC(NSRC), .SEL_W(SEL_W)) u_lock (
    .en(en), .osc_lock(osc_lock), .em4_block(em4_block), .clk_sel(clk_sel),
    .osc_req(osc_req), .deep_sleep_block(deep_sleep_block)
  );
endmodule

// File: rtl/lpwdt_sva.sv
module lpwdt_sva #(
  parameter int NSRC  = 3,
  parameter int CNT_W = 19
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             dbg_halt,
  input logic             dbg_run,
  input logic [2:0]       pwr_mode,
  input logic             clr_hit,
  input logic [CNT_W-1:0] count,
  input logic             rst_req,
  input logic [NSRC-1:0]  osc_req
);
  assert_pulse_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  assert_hold_after_expiry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req && en && !clr_hit |=> $stable(count));

  assert_halt_freeze_R4: assert property (@(posedge clk) disable iff (!rst_n)
    en && dbg_halt && !dbg_run && !clr_hit |=> $stable(count));

  assert_deep_mode_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    en && pwr_mode == 3'd4 && !clr_hit |=> $stable(count));

  assert_clear_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    en && clr_hit |=> count == '0);

  assert_disable_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> count == '0 && !rst_req);

  assert_osc_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(osc_req));
endmodule

bind lpwdt_ctrl lpwdt_sva #(.NSRC(NSRC), .CNT_W(CNT_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .en(en), .dbg_halt(dbg_halt), .dbg_run(dbg_run),
  .pwr_mode(pwr_mode), .clr_hit(clr_hit), .count(count), .rst_req(rst_req),
  .osc_req(osc_req)
);

// File: tb/lpwdt_ctrl_test.sv
module lpwdt_ctrl_test;
  logic        clk = 1'b0, bus_clk = 1'b0;
  logic        rst_n = 1'b0, bus_rst_n = 1'b0;
  logic        clr = 1'b0, en = 1'b0;
  logic [2:0]  src_tick = 3'b111;
  logic [1:0]  clk_sel = 2'd0;
  logic [3:0]  per_sel = 4'd0;
  logic        dbg_halt = 1'b0, dbg_run = 1'b0;
  logic [2:0]  pwr_mode = 3'd0;
  logic        em2_run = 1'b0, em3_run = 1'b0, osc_lock = 1'b0, em4_block = 1'b0;
  logic        rst_req, deep_sleep_block;
  logic [2:0]  osc_req;
  logic [18:0] count;

  int n_checks = 0, n_errors = 0, cyc = 0, s = 0;
  int exp_q[$];
  bit done = 1'b0;

  lpwdt_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_clk(bus_clk), .bus_rst_n(bus_rst_n),
    .clr(clr), .en(en), .src_tick(src_tick), .clk_sel(clk_sel),
    .per_sel(per_sel), .dbg_halt(dbg_halt), .dbg_run(dbg_run),
    .pwr_mode(pwr_mode), .em2_run(em2_run), .em3_run(em3_run),
    .osc_lock(osc_lock), .em4_block(em4_block), .rst_req(rst_req),
    .osc_req(osc_req), .deep_sleep_block(deep_sleep_block), .count(count)
  );

  always #4 clk = ~clk;
  always #5 bus_clk = ~bus_clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // monitor: every reset request must match the next predicted cycle
  always @(negedge clk) begin
    if (rst_n && rst_req) begin
      if (exp_q.size() == 0) check(1'b0, "R3", "unexpected rst_req at cycle", cyc, -1);
      else begin
        int e;
        e = exp_q.pop_front();
        check(cyc == e, "R2", "timeout cycle", cyc, e);
      end
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic restart();
    @(negedge clk) en = 1'b0;
    @(negedge clk) en = 1'b1;
    s = cyc;
  endtask

  task automatic expect_at(input int c);
    exp_q.push_back(c);
  endtask

  task automatic do_clear();
    @(negedge bus_clk) clr = 1'b1;
    @(negedge bus_clk) clr = 1'b0;
    wait_n(8);
  endtask

  task automatic queue_empty(input string req);
    check(exp_q.size() == 0, req, "missing timeout pulses", exp_q.size(), 0);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      check(1'b0, "R2", "watchdog expired", cyc, 0);
      summary();
    end
  end

  initial begin
    wait_n(5);
    rst_n = 1'b1; bus_rst_n = 1'b1;
    wait_n(2);
    // reset / disabled state (R9)
    check(count == 0, "R9", "count at reset", count, 0);
    check(rst_req == 0, "R9", "rst_req at reset", rst_req, 0);
    check(osc_req == 0, "R9", "osc_req at reset", osc_req, 0);
    check(deep_sleep_block == 0, "R9", "deep block at reset", deep_sleep_block, 0);

    // R2/R3: basic timeouts on each source
    per_sel = 4'd0; restart(); expect_at(s + 9);
    wait_n(30);
    check(count == 9, "R3", "held count after expiry", count, 9);
    queue_empty("R2");
    clk_sel = 2'd1; per_sel = 4'd2; restart(); expect_at(s + 33);
    wait_n(50); queue_empty("R2");
    clk_sel = 2'd2; per_sel = 4'd5; restart(); expect_at(s + 257);
    wait_n(280); queue_empty("R2");
    clk_sel = 2'd0; per_sel = 4'd10; restart(); expect_at(s + 8193);
    wait_n(8220); queue_empty("R2");

    // R1: source selection gates the ticks
    clk_sel = 2'd1; src_tick = 3'b101; per_sel = 4'd0; restart();
    wait_n(20);
    check(count == 0, "R1", "count with unselected ticks", count, 0);
    src_tick = 3'b010; wait_n(4);
    check(count == 4, "R1", "count with selected ticks", count, 4);
    clk_sel = 2'd3; src_tick = 3'b111; restart();
    wait_n(20);
    check(count == 0, "R1", "count with no source", count, 0);
    clk_sel = 2'd0;

    // R4/R6: halt freezes then resumes
    restart(); expect_at(s + 19);
    wait_n(3);
    dbg_halt = 1'b1;
    wait_n(10);
    check(count == 3, "R4", "count frozen by halt", count, 3);
    dbg_halt = 1'b0;
    wait_n(20); queue_empty("R6");

    // R4: debug-run keeps counting while halted
    restart(); dbg_halt = 1'b1; dbg_run = 1'b1; expect_at(s + 9);
    wait_n(20); queue_empty("R4");
    dbg_halt = 1'b0; dbg_run = 1'b0;

    // R5/R6: power modes (frozen 5+5+5+3 = 18 cycles)
    restart(); expect_at(s + 27);
    pwr_mode = 3'd2; em2_run = 1'b0; wait_n(5);
    check(count == 0, "R5", "mode2 frozen", count, 0);
    em2_run = 1'b1; wait_n(4);
    check(count == 4, "R5", "mode2 running", count, 4);
    pwr_mode = 3'd3; em3_run = 1'b0; wait_n(5);
    check(count == 4, "R5", "mode3 frozen", count, 4);
    pwr_mode = 3'd4; wait_n(5);
    check(count == 4, "R5", "mode4 frozen", count, 4);
    pwr_mode = 3'd1; wait_n(2);
    check(count == 6, "R5", "mode1 running", count, 6);
    pwr_mode = 3'd5; wait_n(3);
    check(count == 6, "R5", "unused mode frozen", count, 6);
    pwr_mode = 3'd3; em3_run = 1'b1;
    wait_n(10); queue_empty("R6");
    pwr_mode = 3'd0; em2_run = 1'b0; em3_run = 1'b0;

    // R7: clear while frozen
    restart(); wait_n(5);
    dbg_halt = 1'b1;
    do_clear();
    check(count == 0, "R7", "count after clear", count, 0);
    dbg_halt = 1'b0; s = cyc; expect_at(s + 9);
    wait_n(20); queue_empty("R7");

    // R8: clear then period change
    per_sel = 4'd3; restart(); wait_n(40);
    dbg_halt = 1'b1;
    do_clear();
    per_sel = 4'd0;
    check(count == 0, "R8", "count after clear", count, 0);
    dbg_halt = 1'b0; s = cyc; expect_at(s + 9);
    wait_n(100); queue_empty("R8");

    // R9: disable resets, clear while disabled is discarded
    @(negedge clk) en = 1'b0;
    wait_n(1);
    check(count == 0, "R9", "count after disable", count, 0);
    do_clear();
    @(negedge clk) en = 1'b1; s = cyc; expect_at(s + 9);
    wait_n(20); queue_empty("R9");

    // R10/R11: lock outputs
    clk_sel = 2'd2; osc_lock = 1'b1; em4_block = 1'b1; #1;
    check(osc_req == 3'b100, "R10", "osc_req source 2", osc_req, 4);
    check(deep_sleep_block == 1, "R11", "deep block on", deep_sleep_block, 1);
    clk_sel = 2'd0; #1;
    check(osc_req == 3'b001, "R10", "osc_req source 0", osc_req, 1);
    osc_lock = 1'b0; em4_block = 1'b0; #1;
    check(osc_req == 0, "R10", "osc_req unlocked", osc_req, 0);
    check(deep_sleep_block == 0, "R11", "deep block off", deep_sleep_block, 0);
    osc_lock = 1'b1; em4_block = 1'b1;
    @(negedge clk) en = 1'b0; #1;
    check(osc_req == 0, "R10", "osc_req disabled", osc_req, 0);
    check(deep_sleep_block == 0, "R11", "deep block disabled", deep_sleep_block, 0);

    wait_n(5);
    queue_empty("R3");
    done = 1'b1;
    summary();
  end
endmodule